// File: doc/BRIEF.md
# Operand Address Generator

This block turns one operand specifier into either a memory address or a direct operand value. It is given a mode code, two register values (a base and an index), a constant field and a small step/scale value `d`. For register-direct and immediate modes the produced value is the operand itself. For the memory modes it is the address the load/store stage should use. Two modes also return an updated base-register value with a write enable. One mode needs a pointer to be read from memory first; for that the block drives a one-cycle read request and takes the returned word as the final address.

A new specifier is accepted on any cycle where `start` is high and the block is not busy. Results appear on registered outputs with a one-cycle `done` pulse and are held until the next result. The read port expects a synchronous memory: data requested on one clock edge is presented on `mem_rdata` after that edge and is sampled on the following one.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `busy`, `wb_en`, `bad_mode`, `direct` and `mem_req` are 0 and `ea` and `wb_val` are 0.
- R2: Mode 0 (register direct) yields `ea` = base value with `direct` = 1, no write-back and no memory request.
- R3: Mode 1 (immediate) yields `ea` = constant field with `direct` = 1, no write-back and no memory request.
- R4: Mode 2 (base plus offset) yields `ea` = field + base, modulo 2^AW, with `direct` = 0.
- R5: Mode 3 (register indirect) yields `ea` = base; mode 5 (absolute) yields `ea` = field; both with `direct` = 0 and no write-back.
- R6: Mode 4 (indexed) yields `ea` = base + index, modulo 2^AW.
- R7: Mode 6 (memory indirect) raises `mem_req` combinationally in the accepting cycle with `mem_addr` = base, raises `busy` for the next cycle, and pulses `done` two cycles after acceptance with `ea` equal to the word read; `start` while `busy` is 1 is ignored.
- R8: Mode 7 (post-increment) yields `ea` = base, `wb_en` = 1 and `wb_val` = base + d, wrapping modulo 2^AW.
- R9: Mode 8 (pre-decrement) yields `ea` = base - d and `wb_en` = 1 with `wb_val` = base - d, wrapping modulo 2^AW.
- R10: Mode 9 (scaled index) yields `ea` = field + base + index * d, modulo 2^AW.
- R11: Codes 10 to 15 yield `bad_mode` = 1 with `done`, and `wb_en` = 0, `direct` = 0, `ea` = 0 and no memory request.
- R12: For every mode except 6, `done` pulses exactly one cycle after the accepting cycle; `done` never rises without an accepted request, and outputs hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to evaluate the current specifier |
| mode | input | 4 | Addressing mode code 0..15 |
| base_val | input | AW | Base register value |
| index_val | input | AW | Index register value |
| field_val | input | AW | Displacement, immediate or absolute constant |
| step_d | input | DW | Step for auto-update modes, scale for scaled mode |
| mem_req | output | 1 | Pointer read request (memory-indirect only) |
| mem_addr | output | AW | Pointer read address |
| mem_rdata | input | AW | Word returned by the pointer read |
| done | output | 1 | One-cycle result-valid pulse |
| busy | output | 1 | Pointer read outstanding; requests ignored |
| ea | output | AW | Effective address or direct operand value |
| direct | output | 1 | Result is an operand value, not an address |
| wb_en | output | 1 | Base-register write-back enable |
| wb_val | output | AW | Base-register write-back value |
| bad_mode | output | 1 | Mode code is not defined |

## Verification
Every mode code is driven with a set of base, index, field and step values that includes small numbers, all-ones words and mixed patterns, so that swapped operands, a missing term, a wrong sign or a dropped scale produce different results. Boundary runs cover increment past the top of the address space, decrement below zero, scale of zero and of its maximum, and all six undefined codes. Memory-indirect requests are followed by a second request during the busy cycle to show it is dropped, and non-indirect requests are issued back to back to show one result per cycle with `done` low on every other cycle.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int AW = 32,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] field_val,
  input  logic [DW-1:0] step_d,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          busy,
  output logic [AW-1:0] ea,
  output logic          direct,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          bad_mode
);

  localparam logic [3:0] MD_REG  = 4'd0;
  localparam logic [3:0] MD_IMM  = 4'd1;
  localparam logic [3:0] MD_DISP = 4'd2;
  localparam logic [3:0] MD_RIND = 4'd3;
  localparam logic [3:0] MD_IDX  = 4'd4;
  localparam logic [3:0] MD_ABS  = 4'd5;
  localparam logic [3:0] MD_MIND = 4'd6;
  localparam logic [3:0] MD_PINC = 4'd7;
  localparam logic [3:0] MD_PDEC = 4'd8;
  localparam logic [3:0] MD_SCL  = 4'd9;

  logic          pend;
  logic          go;
  logic [AW-1:0] step_w;
  logic [AW-1:0] n_ea, n_wbv;
  logic          n_dir, n_wbe, n_bad;

  assign busy     = pend;
  assign go       = start && !pend;
  assign mem_req  = go && (mode == MD_MIND);
  assign mem_addr = base_val;
  assign step_w   = AW'(step_d);

  always_comb begin
    n_ea  = '0;
    n_wbv = '0;
    n_dir = 1'b0;
    n_wbe = 1'b0;
    n_bad = 1'b0;
    case (mode)
      MD_REG:  begin n_ea = base_val;  n_dir = 1'b1; end
      MD_IMM:  begin n_ea = field_val; n_dir = 1'b1; end
      MD_DISP: n_ea = field_val + base_val;
      MD_RIND: n_ea = base_val;
      MD_IDX:  n_ea = base_val + index_val;
      MD_ABS:  n_ea = field_val;
      MD_MIND: n_ea = '0;
      MD_PINC: begin n_ea = base_val; n_wbe = 1'b1; n_wbv = base_val + step_w; end
      MD_PDEC: begin n_ea = base_val - step_w; n_wbe = 1'b1; n_wbv = base_val - step_w; end
      MD_SCL:  n_ea = field_val + base_val + index_val * step_w;
      default: n_bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      done     <= 1'b0;
      ea       <= '0;
      direct   <= 1'b0;
      wb_en    <= 1'b0;
      wb_val   <= '0;
      bad_mode <= 1'b0;
    end else begin
      done <= 1'b0;
      if (pend) begin
        pend     <= 1'b0;
        done     <= 1'b1;
        ea       <= mem_rdata;
        direct   <= 1'b0;
        wb_en    <= 1'b0;
        wb_val   <= '0;
        bad_mode <= 1'b0;
      end else if (go) begin
        if (mode == MD_MIND) begin
          pend <= 1'b1;
        end else begin
          done     <= 1'b1;
          ea       <= n_ea;
          direct   <= n_dir;
          wb_en    <= n_wbe;
          wb_val   <= n_wbv;
          bad_mode <= n_bad;
        end
      end
    end
  end

  assert_direct_nowb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    direct |-> !wb_en && !bad_mode);

  assert_busy_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done && !busy);

  assert_req_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> busy);

  assert_wb_is_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_en) |-> done && !direct && !bad_mode);

  assert_bad_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> !wb_en && !direct && ea == '0);

  assert_done_has_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(go) || $past(busy));

  assert_hold_between_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea) && $stable(wb_val));

endmodule

// File: tb/opnd_addr_gen_tb.sv
`timescale 1ns/1ps
module opnd_addr_gen_tb;
  localparam int AW = 32;
  localparam int DW = 4;

  typedef struct {
    int          due;
    logic [31:0] ea;
    bit          dir;
    bit          wbe;
    logic [31:0] wbv;
    bit          bad;
    logic [3:0]  m;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [AW-1:0] base_val = '0, index_val = '0, field_val = '0;
  logic [DW-1:0] step_d = '0;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic [AW-1:0] mem_rdata = '0;
  logic done, busy, direct, wb_en, bad_mode;
  logic [AW-1:0] ea, wb_val;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pend_cyc = -10;
  bit chk_en = 1'b0;
  bit finished = 1'b0;
  logic [31:0] last_ea = '0;
  exp_t q[$];

  always #4 clk = ~clk;

  opnd_addr_gen #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .base_val(base_val), .index_val(index_val), .field_val(field_val),
    .step_d(step_d), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .busy(busy), .ea(ea),
    .direct(direct), .wb_en(wb_en), .wb_val(wb_val), .bad_mode(bad_mode)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h1357_9BDF;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) mem_rdata <= memf(mem_addr);
  end

  function automatic string tag(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd5: return "R5";
      4'd4: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [3:0] m, input logic [31:0] b, x, f,
                                 input logic [3:0] d, input int due);
    exp_t e;
    longint unsigned s;
    e.due = due; e.ea = 0; e.dir = 0; e.wbe = 0; e.wbv = 0; e.bad = 0; e.m = m;
    if (m == 0) begin e.ea = b; e.dir = 1; end
    else if (m == 1) begin e.ea = f; e.dir = 1; end
    else if (m == 2) begin s = longint'(f) + longint'(b); e.ea = s[31:0]; end
    else if (m == 3) e.ea = b;
    else if (m == 4) begin s = longint'(b) + longint'(x); e.ea = s[31:0]; end
    else if (m == 5) e.ea = f;
    else if (m == 6) e.ea = memf(b);
    else if (m == 7) begin e.ea = b; e.wbe = 1; s = longint'(b) + longint'(d); e.wbv = s[31:0]; end
    else if (m == 8) begin
      s = longint'(b) + 64'h1_0000_0000 - longint'(d);
      e.ea = s[31:0]; e.wbe = 1; e.wbv = s[31:0];
    end
    else if (m == 9) begin
      s = longint'(f) + longint'(b) + longint'(x) * longint'(d);
      e.ea = s[31:0];
    end
    else e.bad = 1;
    return e;
  endfunction

  always @(negedge clk) begin
    if (chk_en) begin
      chk(busy == (cyc == pend_cyc), "R7", "busy", 32'(busy), 32'(cyc == pend_cyc));
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(done === 1'b1, tag(e.m), "done", 32'(done), 1);
        chk(ea === e.ea, tag(e.m), "ea", ea, e.ea);
        chk(direct === e.dir, tag(e.m), "direct", 32'(direct), 32'(e.dir));
        chk(wb_en === e.wbe, tag(e.m), "wb_en", 32'(wb_en), 32'(e.wbe));
        if (e.wbe) chk(wb_val === e.wbv, tag(e.m), "wb_val", wb_val, e.wbv);
        chk(bad_mode === e.bad, tag(e.m), "bad_mode", 32'(bad_mode), 32'(e.bad));
        last_ea = e.ea;
      end else begin
        chk(done === 1'b0, "R12", "spurious done", 32'(done), 0);
        chk(ea === last_ea, "R12", "ea hold", ea, last_ea);
      end
    end
  end

  task automatic issue(input logic [3:0] m, input logic [31:0] b, x, f, input logic [3:0] d);
    bit acc;
    acc = (cyc != pend_cyc);
    start = 1'b1; mode = m; base_val = b; index_val = x; field_val = f; step_d = d;
    #1;
    chk(mem_req === (acc && m == 4'd6), (m == 4'd6) ? "R7" : tag(m), "mem_req",
        32'(mem_req), 32'(acc && m == 4'd6));
    if (mem_req) chk(mem_addr === b, "R7", "mem_addr", mem_addr, b);
    if (acc) begin
      q.push_back(model(m, b, x, f, d, cyc + ((m == 4'd6) ? 2 : 1)));
      if (m == 4'd6) pend_cyc = cyc + 1;
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] bv[6];
    logic [31:0] xv[6];
    logic [31:0] fv[6];
    logic [3:0]  dv[6];
    bv = '{32'h0000_0010, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h0, 32'hA5A5_5A5A};
    xv = '{32'h0000_0003, 32'h0000_0001, 32'h7FFF_FFFF, 32'h0000_0100, 32'hFFFF_FFFE, 32'h3C3C_0F0F};
    fv = '{32'h0000_0400, 32'h0000_0001, 32'hFFFF_FF00, 32'hCAFE_0000, 32'h0000_FFFF, 32'h0F0F_F0F0};
    dv = '{4'd4, 4'd1, 4'd8, 4'd2, 4'd15, 4'd0};

    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk(done === 0 && busy === 0 && wb_en === 0 && bad_mode === 0 && direct === 0,
        "R1", "flags in reset", {27'd0, done, busy, wb_en, bad_mode, direct}, 0);
    chk(ea === 0 && wb_val === 0, "R1", "values in reset", ea | wb_val, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 0 && busy === 0 && mem_req === 0, "R1", "after release",
        {29'd0, done, busy, mem_req}, 0);
    chk_en = 1'b1;

    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 6; k++)
        issue(4'(m), bv[k], xv[k], fv[k], dv[k]);
      idle(2);
    end

    // R8 / R9 wrap boundaries
    issue(4'd7, 32'hFFFF_FFFF, 0, 0, 4'd1);
    issue(4'd8, 32'h0000_0000, 0, 0, 4'd1);
    issue(4'd8, 32'h0000_0005, 0, 0, 4'd15);
    // R10 scale zero and max
    issue(4'd9, 32'h100, 32'hFFFF_FFFF, 32'h20, 4'd0);
    issue(4'd9, 32'h100, 32'h1111_1111, 32'h20, 4'd15);
    idle(2);

    // R7: start during busy is ignored, then back-to-back indirect
    issue(4'd6, 32'h0000_2000, 0, 0, 4'd0);
    issue(4'd1, 32'h0, 0, 32'hDEAD_BEEF, 4'd0);
    issue(4'd6, 32'h0000_3004, 0, 0, 4'd0);
    issue(4'd7, 32'h50, 0, 0, 4'd4);
    idle(1);
    issue(4'd2, 32'h40, 0, 32'h4, 4'd0);
    idle(3);

    // R12 long mixed back-to-back stream
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      r = 32'(k) * 32'h9E37_79B9 + 32'h1234;
      issue(r[3:0], r ^ 32'h0F0F_0F0F, r >> 3, ~r, r[7:4]);
    end
    idle(4);
    chk(q.size() == 0, "R12", "all results seen", q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule